// File: doc/BRIEF.md
# Two-Wire Serial Slave with Busy Refusal

This block is the serial target side of a two-wire bus (I2C style). It samples the clock and data lines with the system clock and filters out short spikes. It finds the conditions that open and close a transfer, and it decodes the first byte as a device address. That address is a fixed four-bit identifier, `1011`, followed by three bits that come from a programmable address register in the surrounding logic. The data line is modelled as a single drive-low enable; the open-drain pad is outside the block.

After a write address, the first data byte loads a register pointer. Each later byte is presented on a one-cycle write strobe at the pointer, and the pointer then steps forward. After a read address, the block shifts out bytes MSB first, starting at the current pointer. It moves to the next byte each time the master acknowledges, and it lets go of the line when the master does not acknowledge. A `busy` input marks a nonvolatile write in progress. While it is high, the block refuses every address and data byte by leaving the line released.

Top module: `tws_top`

## Requirements
- R1: After reset, `sdaDriveLow` is 0, `regWrEn` is 0 and `regPtr` is 0.
- R2: The block acknowledges an address byte only when bits 7..4 equal `1011` and bits 3..1 equal `addrSel`. On any other address it releases SDA and ignores every later byte until the next START.
- R3: An acknowledge holds SDA low for the whole high phase of the ninth clock. `sdaDriveLow` changes only while SCL is low.
- R4: In a write transfer (address bit 0 = 0), the first data byte sets `regPtr`. Each later byte gives one `regWrEn` pulse with `regWrAddr` equal to the pointer and `regWrData` equal to the byte, and the pointer then increases by one. Every byte is acknowledged.
- R5: In a read transfer (address bit 0 = 1), bytes are sent MSB first. The first byte is `regRdData` at the current pointer. The pointer increases by one after each byte, and the next byte follows whenever the master acknowledges.
- R6: When the master does not acknowledge a read byte, `sdaDriveLow` stays 0 until the next START.
- R7: While `busy` is 1, address and write-data bytes are not acknowledged and no `regWrEn` pulse occurs. Normal replies return once `busy` is 0.
- R8: A STOP (SDA rising while SCL is high) at any bit returns the block to idle. Bytes clocked after it without a START get no acknowledge and cause no write.
- R9: A repeated START in the middle of a transfer starts a new address phase at once.
- R10: A low pulse on SDA that is shorter than `FILT_LEN` system clocks is not taken as a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaDriveLow | output | 1 | 1 pulls the data line low |
| addrSel | input | 3 | Programmable low address bits |
| busy | input | 1 | Nonvolatile write in progress; forces refusal |
| regPtr | output | PTR_W | Register pointer used as the read address |
| regRdData | input | 8 | Register contents at `regPtr` |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrAddr | output | PTR_W | Register write address |
| regWrData | output | 8 | Register write data |

## Verification
The bench targets the places where a slave of this kind goes wrong. It checks that the pointer byte is not also written as data, which would give an extra write at the old pointer. It checks that a master NACK really releases the line; a design that kept shifting would block the STOP. It raises `busy` in the middle of a write, where a weak design would still acknowledge and write the refused byte. It clocks whole address bytes after a mismatch, after a STOP in mid-byte, and after a one-cycle SDA glitch. A block that skipped the return to idle, or took the glitch as a START, would acknowledge bytes it must ignore. A repeated START that moves from a pointer write straight into a read checks that a design does not wait for idle before it decodes the new address.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef struct packed {
    logic shiftIn;   // sample SDA into the receive register
    logic clrCnt;    // clear bit counter
    logic loadTx;    // load transmit register from register data
    logic shiftTx;   // advance transmit register by one bit
    logic setPtr;    // pointer <= received byte
    logic wrByte;    // emit register write and step pointer
    logic incPtr;    // step pointer after a sent byte
  } twsStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WRITE,
    ST_READ,
    ST_MACK
  } twsState_t;
endpackage

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int FILT_LEN = 3,
  parameter int PTR_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  twsStrobe_t       strb,
  input  logic [7:0]       regRdData,
  output logic             sclRise,
  output logic             sclFall,
  output logic             startDet,
  output logic             stopDet,
  output logic             sdaFilt,
  output logic [3:0]       bitCnt,
  output logic [7:0]       rxByte,
  output logic             txMsb,
  output logic [PTR_W-1:0] regPtr,
  output logic             regWrEn,
  output logic [PTR_W-1:0] regWrAddr,
  output logic [7:0]       regWrData
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [1:0] pinRaw;
  logic [1:0] pinFilt;
  logic [1:0] pinPrev;

  assign pinRaw = {sdaIn, sclIn};

  // Two-flop synchronizer plus run-length spike filter on each line
  for (genvar i = 0; i < 2; i++) begin : g_filt
    logic [1:0]       syncQ;
    logic [CNT_W-1:0] runQ;
    logic             filtQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= 2'b11;
        runQ  <= '0;
        filtQ <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], pinRaw[i]};
        if (syncQ[1] == filtQ) begin
          runQ <= '0;
        end else if (runQ == CNT_W'(FILT_LEN - 1)) begin
          filtQ <= syncQ[1];
          runQ  <= '0;
        end else begin
          runQ <= runQ + 1'b1;
        end
      end
    end
    assign pinFilt[i] = filtQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= 2'b11;
    else       pinPrev <= pinFilt;
  end

  logic sclF, sclP, sdaP;
  assign sclF     = pinFilt[0];
  assign sdaFilt  = pinFilt[1];
  assign sclP     = pinPrev[0];
  assign sdaP     = pinPrev[1];
  assign sclRise  = sclF & ~sclP;
  assign sclFall  = ~sclF & sclP;
  assign startDet = sclF & sclP & sdaP & ~sdaFilt;
  assign stopDet  = sclF & sclP & ~sdaP & sdaFilt;

  logic [7:0] txQ;
  assign txMsb = txQ[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      rxByte    <= '0;
      txQ       <= 8'hFF;
      regPtr    <= '0;
      regWrEn   <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
    end else begin
      regWrEn <= strb.wrByte;
      if (strb.clrCnt)                      bitCnt <= '0;
      else if (strb.shiftIn || strb.shiftTx) bitCnt <= bitCnt + 1'b1;
      if (strb.shiftIn) rxByte <= {rxByte[6:0], sdaFilt};
      if (strb.loadTx)       txQ <= regRdData;
      else if (strb.shiftTx) txQ <= {txQ[6:0], 1'b1};
      if (strb.setPtr) begin
        regPtr <= rxByte[PTR_W-1:0];
      end else if (strb.wrByte) begin
        regWrAddr <= regPtr;
        regWrData <= rxByte;
        regPtr    <= regPtr + 1'b1;
      end else if (strb.incPtr) begin
        regPtr <= regPtr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tws_control.sv
module tws_control
  import tws_pkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'b1011
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaFilt,
  input  logic [3:0] bitCnt,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  input  logic [2:0] addrSel,
  input  logic       busy,
  output twsStrobe_t strb,
  output logic       sdaDriveLow
);
  twsState_t state, stateNxt;
  logic ackQ, ackNxt;
  logic rwQ, rwNxt;
  logic firstQ, firstNxt;
  logic mAckQ, mAckNxt;
  logic byteDone, addrHit;

  assign byteDone = sclFall && (bitCnt == 4'd8);
  assign addrHit  = (rxByte[7:4] == DEV_ID) && (rxByte[3:1] == addrSel);

  always_comb begin
    stateNxt = state;
    ackNxt   = ackQ;
    rwNxt    = rwQ;
    firstNxt = firstQ;
    mAckNxt  = mAckQ;
    strb     = '0;
    if (stopDet) begin
      stateNxt = ST_IDLE;
      ackNxt   = 1'b0;
    end else if (startDet) begin
      stateNxt    = ST_ADDR;
      ackNxt      = 1'b0;
      strb.clrCnt = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR: begin
          strb.shiftIn = sclRise;
          if (byteDone) begin
            if (addrHit && !busy) begin
              stateNxt = ST_ACK;
              ackNxt   = 1'b1;
              rwNxt    = rxByte[0];
              firstNxt = 1'b1;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        ST_WRITE: begin
          strb.shiftIn = sclRise;
          if (byteDone) begin
            if (busy) begin
              stateNxt = ST_IDLE;
            end else begin
              stateNxt = ST_ACK;
              ackNxt   = 1'b1;
              firstNxt = 1'b0;
              if (firstQ) strb.setPtr = 1'b1;
              else        strb.wrByte = 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            ackNxt      = 1'b0;
            strb.clrCnt = 1'b1;
            if (rwQ) begin
              stateNxt    = ST_READ;
              strb.loadTx = 1'b1;
            end else begin
              stateNxt = ST_WRITE;
            end
          end
        end
        ST_READ: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stateNxt    = ST_MACK;
              strb.incPtr = 1'b1;
            end else begin
              strb.shiftTx = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) mAckNxt = ~sdaFilt;
          if (sclFall) begin
            if (mAckQ) begin
              stateNxt    = ST_READ;
              strb.loadTx = 1'b1;
              strb.clrCnt = 1'b1;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      ackQ   <= 1'b0;
      rwQ    <= 1'b0;
      firstQ <= 1'b0;
      mAckQ  <= 1'b0;
    end else begin
      state  <= stateNxt;
      ackQ   <= ackNxt;
      rwQ    <= rwNxt;
      firstQ <= firstNxt;
      mAckQ  <= mAckNxt;
    end
  end

  assign sdaDriveLow = ackQ | ((state == ST_READ) & ~txMsb);
endmodule

// File: rtl/tws_top.sv
module tws_top
  import tws_pkg::*;
#(
  parameter int         FILT_LEN = 3,
  parameter int         PTR_W    = 8,
  parameter logic [3:0] DEV_ID   = 4'b1011
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaDriveLow,
  input  logic [2:0]       addrSel,
  input  logic             busy,
  output logic [PTR_W-1:0] regPtr,
  input  logic [7:0]       regRdData,
  output logic             regWrEn,
  output logic [PTR_W-1:0] regWrAddr,
  output logic [7:0]       regWrData
);
  twsStrobe_t strb;
  logic       sclRise, sclFall, startDet, stopDet, sdaFilt, txMsb;
  logic [3:0] bitCnt;
  logic [7:0] rxByte;

  tws_datapath #(.FILT_LEN(FILT_LEN), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .regRdData(regRdData), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaFilt(sdaFilt),
    .bitCnt(bitCnt), .rxByte(rxByte), .txMsb(txMsb), .regPtr(regPtr),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData)
  );

  tws_control #(.DEV_ID(DEV_ID)) u_ctl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaFilt(sdaFilt),
    .bitCnt(bitCnt), .rxByte(rxByte), .txMsb(txMsb), .addrSel(addrSel),
    .busy(busy), .strb(strb), .sdaDriveLow(sdaDriveLow)
  );
endmodule

// File: rtl/tws_checker.sv
module tws_checker #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             sdaDriveLow,
  input logic             busy,
  input logic [PTR_W-1:0] regPtr,
  input logic             regWrEn,
  input logic [PTR_W-1:0] regWrAddr
);
  // R3
  sda_change_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclIn);

  // R7
  busy_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !$past(busy));

  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R4
  ptr_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regPtr == PTR_W'(regWrAddr + 1'b1)));
endmodule

bind tws_top tws_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow),
  .busy(busy), .regPtr(regPtr), .regWrEn(regWrEn), .regWrAddr(regWrAddr)
);

// File: tb/tws_top_tb.sv
module tws_top_tb;
  localparam int H = 20;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] AW = 8'hBA;
  localparam logic [7:0] AR = 8'hBB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic busy = 1'b0;
  logic sdaBus;
  logic sdaDriveLow;
  logic [7:0] regPtr, regRdData, regWrAddr, regWrData;
  logic regWrEn;
  logic [7:0] mem [256];
  int total = 0;
  int bad = 0;
  int driveCnt = 0;
  int wrCnt = 0;

  always #2 clk = ~clk;

  assign sdaBus = mSda & ~sdaDriveLow;
  assign regRdData = mem[regPtr];

  tws_top u_dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .addrSel(SEL), .busy(busy),
    .regPtr(regPtr), .regRdData(regRdData), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData)
  );

  function automatic logic [7:0] initVal(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= initVal(i);
    end else if (regWrEn) begin
      mem[regWrAddr] <= regWrData;
    end
  end

  always @(negedge clk) begin
    if (sdaDriveLow) driveCnt++;
    if (regWrEn) wrCnt++;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitH();
    repeat (H) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitH(); scl = 1'b1; waitH(); mSda = 1'b0; waitH(); scl = 1'b0;
  endtask

  task automatic busStop();
    mSda = 1'b0; waitH(); scl = 1'b1; waitH(); mSda = 1'b1; waitH();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mSda = b[i]; waitH(); scl = 1'b1; waitH(); scl = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic s1, s2;
    sendBits(b, 8);
    mSda = 1'b1; waitH(); scl = 1'b1;
    repeat (H/2) @(negedge clk); s1 = sdaBus;
    repeat (H/2 - 1) @(negedge clk); s2 = sdaBus;
    @(negedge clk); scl = 1'b0;
    acked = !s1 && !s2;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] d);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitH(); scl = 1'b1;
      repeat (H/2) @(negedge clk); d[i] = sdaBus;
      repeat (H/2) @(negedge clk); scl = 1'b0;
    end
    mSda = !giveAck; waitH(); scl = 1'b1; waitH(); scl = 1'b0;
  endtask

  // {address byte, busy, expected ack}
  localparam logic [9:0] VEC [8] = '{
    {8'hBA, 1'b0, 1'b1}, {8'hBB, 1'b0, 1'b1}, {8'hB8, 1'b0, 1'b0},
    {8'hAA, 1'b0, 1'b0}, {8'h3A, 1'b0, 1'b0}, {8'hBA, 1'b1, 1'b0},
    {8'hBB, 1'b1, 1'b0}, {8'hFA, 1'b0, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int dc, wc;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sdaDriveLow == 1'b0, "R1 drive", sdaDriveLow, 0);
    check(regWrEn == 1'b0, "R1 wren", regWrEn, 0);
    check(regPtr == 8'h00, "R1 ptr", regPtr, 0);
    waitH();

    // R2 R7 address table
    foreach (VEC[k]) begin
      busy = VEC[k][1];
      busStart();
      sendByte(VEC[k][9:2], ack);
      check(ack == VEC[k][0], "R2/R7 addr ack", ack, VEC[k][0]);
      if (ack && VEC[k][2]) readByte(1'b0, d);
      busStop();
      busy = 1'b0;
    end

    // R4 R3 write: pointer byte then three data bytes
    wc = wrCnt;
    busStart();
    sendByte(AW, ack);   check(ack, "R3 addr ack", ack, 1);
    sendByte(8'h03, ack); check(ack, "R4 ptr ack", ack, 1);
    sendByte(8'h11, ack); check(ack, "R4 data ack", ack, 1);
    sendByte(8'h22, ack); check(ack, "R4 data ack", ack, 1);
    sendByte(8'h33, ack); check(ack, "R4 data ack", ack, 1);
    busStop();
    check(wrCnt - wc == 3, "R4 write count", wrCnt - wc, 3);
    check(mem[3] == 8'h11, "R4 mem3", mem[3], 8'h11);
    check(mem[4] == 8'h22, "R4 mem4", mem[4], 8'h22);
    check(mem[5] == 8'h33, "R4 mem5", mem[5], 8'h33);
    check(regPtr == 8'h06, "R4 ptr", regPtr, 6);

    // R9 R5 R6 pointer set, repeated START, read three bytes
    busStart();
    sendByte(AW, ack);    check(ack, "R9 addr ack", ack, 1);
    sendByte(8'h20, ack); check(ack, "R9 ptr ack", ack, 1);
    busStart();
    sendByte(AR, ack);    check(ack, "R9 read addr ack", ack, 1);
    readByte(1'b1, d); check(d == initVal(32), "R5 byte0", d, initVal(32));
    readByte(1'b1, d); check(d == initVal(33), "R5 byte1", d, initVal(33));
    dc = driveCnt;
    readByte(1'b0, d); check(d == initVal(34), "R5 byte2", d, initVal(34));
    dc = driveCnt;
    waitH();
    check(driveCnt == dc, "R6 released", driveCnt - dc, 0);
    busStop();
    check(regPtr == 8'h23, "R5 ptr", regPtr, 8'h23);

    // R7 busy during write data, then resume
    wc = wrCnt;
    busStart();
    sendByte(AW, ack);    check(ack, "R7 addr ack", ack, 1);
    sendByte(8'h40, ack); check(ack, "R7 ptr ack", ack, 1);
    busy = 1'b1;
    sendByte(8'h77, ack); check(!ack, "R7 busy nack", ack, 0);
    busStop();
    busy = 1'b0;
    check(wrCnt == wc, "R7 no write", wrCnt - wc, 0);
    check(mem[64] == initVal(64), "R7 mem kept", mem[64], initVal(64));
    busStart();
    sendByte(AW, ack);    check(ack, "R7 resume addr", ack, 1);
    sendByte(8'h40, ack);
    sendByte(8'h77, ack); check(ack, "R7 resume data", ack, 1);
    busStop();
    check(mem[64] == 8'h77, "R7 mem written", mem[64], 8'h77);

    // R2 mismatch: later bytes ignored
    dc = driveCnt; wc = wrCnt;
    busStart();
    sendByte(8'hB0, ack); check(!ack, "R2 mismatch nack", ack, 0);
    sendByte(8'h00, ack); check(!ack, "R2 follow nack", ack, 0);
    busStop();
    check(driveCnt == dc && wrCnt == wc, "R2 silent", driveCnt - dc, 0);

    // R8 STOP mid-byte, then unframed byte
    busStart();
    sendByte(AW, ack);
    sendByte(8'h0A, ack);
    sendBits(8'hC0, 4);
    busStop();
    dc = driveCnt; wc = wrCnt;
    waitH(); scl = 1'b0;
    sendByte(AW, ack);    check(!ack, "R8 idle nack", ack, 0);
    sendByte(8'hFF, ack); check(!ack, "R8 idle nack2", ack, 0);
    busStop();
    check(driveCnt == dc && wrCnt == wc, "R8 silent", driveCnt - dc, 0);
    check(mem[10] == initVal(10), "R8 mem kept", mem[10], initVal(10));

    // R10 one-cycle SDA glitch while SCL high is not a START
    dc = driveCnt;
    @(negedge clk); mSda = 1'b0;
    @(negedge clk); mSda = 1'b1;
    waitH(); scl = 1'b0;
    sendByte(AW, ack); check(!ack, "R10 glitch ignored", ack, 0);
    busStop();
    check(driveCnt == dc, "R10 silent", driveCnt - dc, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule